// File: doc/BRIEF.md
# Operand Staging and Result Commit Sequencer

This block sits beside an external arithmetic unit and runs the two data-movement phases of an instruction: staging operands before the computation and committing results after it. It receives a decoded opcode, two register indices (A and B) and a 16-bit effective address. In the staging phase it fills two 32-bit staging registers, the primary operand `stage_s` and the secondary operand `stage_rz`. Their sources are the register file, a memory word or the effective address itself. For jumps it loads a 16-bit jump-target register instead.

In the commit phase it writes `stage_s` back to register A or to memory. For divide-with-remainder it also writes `stage_rz` to the register after A. Some opcodes commit nothing. The arithmetic unit reads and modifies the staging registers between the two phases, but that logic, the branch decision and instruction fetch all live elsewhere.

Each phase starts with a valid/ready handshake. `start_valid` must stay high with its fields steady until a rising edge where `start_ready` is also high. The fields are captured on that edge. `start_ready` stays low from then until the phase has finished. The memory port has a fixed one-cycle read latency and applies no back-pressure. The register-file read is combinational.

Top module: `operand_stager`

## Requirements
- R1: Staging for opcodes 0x00–0x05, 0x13 and 0x14 sets `stage_s` to register A and `stage_rz` to the memory word at the effective address, with exactly one memory read.
- R2: Staging for opcodes 0x20–0x25, 0x33 and 0x34 sets `stage_s` to register A and `stage_rz` to register B, with no memory access.
- R3: Staging for opcode 0x10 sets `stage_s` to register A and leaves `stage_rz` unchanged, with no memory access.
- R4: Staging for opcode 0x11 sets `stage_s` to the zero-extended effective address, with no register read and no memory access.
- R5: Staging for opcodes 0x80–0x86 and 0x93–0x96 loads `jump_addr` with the effective address and leaves `stage_s`, `stage_rz`, the register file and memory untouched. Staging for 0x99 and for undefined opcodes changes nothing.
- R6: Commit for opcodes 0x04, 0x14, 0x24 and 0x34 writes `stage_s` to register A and `stage_rz` to register (A+1) mod 16.
- R7: Commit for opcodes 0x00–0x03, 0x11, 0x13, 0x20–0x23 and 0x33 writes `stage_s` to register A only.
- R8: Commit for opcode 0x10 writes `stage_s` to memory at the effective address and writes no register.
- R9: Commit for 0x05, 0x25, the jumps, 0x99 and undefined opcodes writes nothing.
- R10: `start_ready` is high only when the block is idle. `done` is a one-cycle pulse in the third cycle after the accepting edge, and all phase results are visible by then.
- R11: The staging phase never writes. The commit phase never reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_valid | input | 1 | Phase request valid |
| start_ready | output | 1 | Block idle, request is taken |
| start_wb | input | 1 | 0 = staging phase, 1 = commit phase |
| start_opcode | input | 8 | Decoded opcode |
| start_r1 | input | 4 | Register index A |
| start_r2 | input | 4 | Register index B |
| start_addr | input | 16 | Effective address |
| done | output | 1 | One-cycle end-of-phase pulse |
| rf_rd_en | output | 1 | Register read strobe |
| rf_rd_addr | output | 4 | Register read index |
| rf_rd_data | input | 32 | Register read data (same cycle) |
| rf_wr_en | output | 1 | Register write strobe |
| rf_wr_addr | output | 4 | Register write index |
| rf_wr_data | output | 32 | Register write data |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_wr_en | output | 1 | Memory write strobe |
| mem_addr | output | 16 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Memory read data, one cycle after the strobe |
| stage_s | output | 32 | Primary staging register |
| stage_rz | output | 32 | Secondary staging register |
| jump_addr | output | 16 | Jump-target register |

## Verification
Every phase has the same timing. It is accepted on a rising edge and runs for two working cycles: register A and the memory read in the first, then register B or the returning memory word in the second. `done` rises in the third cycle. The bench counts falling edges from the accepting edge and expects `done` at the third one and low at the fourth. It reads `stage_s`, `stage_rz`, `jump_addr`, its register model and its memory model only after `done`, when every write of the phase has landed. Strobe counters, cleared before each phase, show whether reads or writes happened.

// File: rtl/opstage_pkg.sv
package opstage_pkg;
  typedef enum logic [2:0] {
    SRC_NONE, SRC_MEM, SRC_REGS, SRC_AONLY, SRC_ADDR, SRC_JUMP
  } src_e;

  typedef enum logic [1:0] {
    DST_NONE, DST_REG, DST_PAIR, DST_MEM
  } dst_e;

  typedef enum logic [1:0] {
    SQ_IDLE, SQ_STEP1, SQ_STEP2, SQ_FIN
  } seq_e;

  typedef struct packed {
    src_e src;
    dst_e dst;
  } route_t;
endpackage

// File: rtl/opstage_decode.sv
module opstage_decode
  import opstage_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output route_t          route
);
  always_comb begin
    route.src = SRC_NONE;
    route.dst = DST_NONE;
    case (opcode)
      8'h00, 8'h01, 8'h02, 8'h03, 8'h13: begin
        route.src = SRC_MEM;  route.dst = DST_REG;
      end
      8'h04, 8'h14: begin
        route.src = SRC_MEM;  route.dst = DST_PAIR;
      end
      8'h05: route.src = SRC_MEM;
      8'h10: begin
        route.src = SRC_AONLY; route.dst = DST_MEM;
      end
      8'h11: begin
        route.src = SRC_ADDR; route.dst = DST_REG;
      end
      8'h20, 8'h21, 8'h22, 8'h23, 8'h33: begin
        route.src = SRC_REGS; route.dst = DST_REG;
      end
      8'h24, 8'h34: begin
        route.src = SRC_REGS; route.dst = DST_PAIR;
      end
      8'h25: route.src = SRC_REGS;
      8'h80, 8'h81, 8'h82, 8'h83, 8'h84, 8'h85, 8'h86,
      8'h93, 8'h94, 8'h95, 8'h96: route.src = SRC_JUMP;
      default: ;
    endcase
  end
endmodule

// File: rtl/opstage_seq.sv
module opstage_seq
  import opstage_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_valid,
  output logic start_ready,
  output logic accept,
  output logic step1,
  output logic step2,
  output logic done
);
  seq_e state_q, state_d;

  assign start_ready = (state_q == SQ_IDLE);
  assign accept      = start_valid && start_ready;
  assign step1       = (state_q == SQ_STEP1);
  assign step2       = (state_q == SQ_STEP2);
  assign done        = (state_q == SQ_FIN);

  always_comb begin
    state_d = state_q;
    case (state_q)
      SQ_IDLE:  if (start_valid) state_d = SQ_STEP1;
      SQ_STEP1: state_d = SQ_STEP2;
      SQ_STEP2: state_d = SQ_FIN;
      default:  state_d = SQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) state_q <= SQ_IDLE;
    else        state_q <= state_d;
endmodule

// File: rtl/opstage_load.sv
module opstage_load
  import opstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int RIDX_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              active,
  input  logic              step1,
  input  logic              step2,
  input  src_e              src,
  input  logic [RIDX_W-1:0] idx_a,
  input  logic [RIDX_W-1:0] idx_b,
  input  logic [ADDR_W-1:0] eff,
  output logic              rf_rd_en,
  output logic [RIDX_W-1:0] rf_rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              mem_rd_en,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] stage_s,
  output logic [DATA_W-1:0] stage_rz,
  output logic [ADDR_W-1:0] jump_addr
);
  logic want_a, want_b;

  assign want_a     = (src == SRC_MEM) || (src == SRC_REGS) || (src == SRC_AONLY);
  assign want_b     = (src == SRC_REGS);
  assign rf_rd_en   = active && ((step1 && want_a) || (step2 && want_b));
  assign rf_rd_addr = step2 ? idx_b : idx_a;
  assign mem_rd_en  = active && step1 && (src == SRC_MEM);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_s   <= '0;
      stage_rz  <= '0;
      jump_addr <= '0;
    end else if (active) begin
      if (step1) begin
        if (want_a)           stage_s   <= rf_rd_data;
        if (src == SRC_ADDR)  stage_s   <= DATA_W'(eff);
        if (src == SRC_JUMP)  jump_addr <= eff;
      end
      if (step2) begin
        if (src == SRC_MEM)   stage_rz  <= mem_rdata;
        if (want_b)           stage_rz  <= rf_rd_data;
      end
    end
  end
endmodule

// File: rtl/opstage_commit.sv
module opstage_commit
  import opstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int RIDX_W = 4
) (
  input  logic              active,
  input  logic              step1,
  input  logic              step2,
  input  dst_e              dst,
  input  logic [RIDX_W-1:0] idx_a,
  input  logic [DATA_W-1:0] stage_s,
  input  logic [DATA_W-1:0] stage_rz,
  output logic              rf_wr_en,
  output logic [RIDX_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_wr_en,
  output logic [DATA_W-1:0] mem_wdata
);
  localparam logic [RIDX_W-1:0] ONE = RIDX_W'(1);
  logic first_reg, second_reg;

  assign first_reg  = step1 && ((dst == DST_REG) || (dst == DST_PAIR));
  assign second_reg = step2 && (dst == DST_PAIR);
  assign rf_wr_en   = active && (first_reg || second_reg);
  assign rf_wr_addr = second_reg ? idx_a + ONE : idx_a;
  assign rf_wr_data = second_reg ? stage_rz : stage_s;
  assign mem_wr_en  = active && step1 && (dst == DST_MEM);
  assign mem_wdata  = stage_s;
endmodule

// File: rtl/operand_stager.sv
module operand_stager
  import opstage_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 16,
  parameter int RIDX_W = 4,
  parameter int OP_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_valid,
  output logic              start_ready,
  input  logic              start_wb,
  input  logic [OP_W-1:0]   start_opcode,
  input  logic [RIDX_W-1:0] start_r1,
  input  logic [RIDX_W-1:0] start_r2,
  input  logic [ADDR_W-1:0] start_addr,
  output logic              done,
  output logic              rf_rd_en,
  output logic [RIDX_W-1:0] rf_rd_addr,
  input  logic [DATA_W-1:0] rf_rd_data,
  output logic              rf_wr_en,
  output logic [RIDX_W-1:0] rf_wr_addr,
  output logic [DATA_W-1:0] rf_wr_data,
  output logic              mem_rd_en,
  output logic              mem_wr_en,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic [DATA_W-1:0] stage_s,
  output logic [DATA_W-1:0] stage_rz,
  output logic [ADDR_W-1:0] jump_addr
);
  logic              accept, step1, step2;
  logic              wb_q;
  logic [OP_W-1:0]   op_q;
  logic [RIDX_W-1:0] a_q, b_q;
  logic [ADDR_W-1:0] eff_q;
  route_t            route;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_q  <= 1'b0;
      op_q  <= '0;
      a_q   <= '0;
      b_q   <= '0;
      eff_q <= '0;
    end else if (accept) begin
      wb_q  <= start_wb;
      op_q  <= start_opcode;
      a_q   <= start_r1;
      b_q   <= start_r2;
      eff_q <= start_addr;
    end
  end

  assign mem_addr = eff_q;

  opstage_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start_valid(start_valid),
    .start_ready(start_ready), .accept(accept),
    .step1(step1), .step2(step2), .done(done)
  );

  opstage_decode #(.OP_W(OP_W)) u_dec (.opcode(op_q), .route(route));

  opstage_load #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .RIDX_W(RIDX_W)) u_load (
    .clk(clk), .rst_n(rst_n), .active(!wb_q), .step1(step1), .step2(step2),
    .src(route.src), .idx_a(a_q), .idx_b(b_q), .eff(eff_q),
    .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr), .rf_rd_data(rf_rd_data),
    .mem_rd_en(mem_rd_en), .mem_rdata(mem_rdata),
    .stage_s(stage_s), .stage_rz(stage_rz), .jump_addr(jump_addr)
  );

  opstage_commit #(.DATA_W(DATA_W), .RIDX_W(RIDX_W)) u_commit (
    .active(wb_q), .step1(step1), .step2(step2), .dst(route.dst),
    .idx_a(a_q), .stage_s(stage_s), .stage_rz(stage_rz),
    .rf_wr_en(rf_wr_en), .rf_wr_addr(rf_wr_addr), .rf_wr_data(rf_wr_data),
    .mem_wr_en(mem_wr_en), .mem_wdata(mem_wdata)
  );
endmodule

// File: rtl/opstage_chk.sv
module opstage_chk #(
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              start_valid,
  input logic              start_ready,
  input logic              start_wb,
  input logic              done,
  input logic              rf_rd_en,
  input logic              rf_wr_en,
  input logic              mem_rd_en,
  input logic              mem_wr_en,
  input logic [DATA_W-1:0] stage_s,
  input logic [DATA_W-1:0] stage_rz
);
  logic busy, ph_wb;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      ph_wb <= 1'b0;
    end else if (start_valid && start_ready) begin
      busy  <= 1'b1;
      ph_wb <= start_wb;
    end else if (done) begin
      busy  <= 1'b0;
    end
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R10
  AST_DONE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(start_valid && start_ready, 3)); // R10
  AST_READY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (start_valid && start_ready) |=> !start_ready); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !(rf_wr_en || mem_wr_en || mem_rd_en || rf_rd_en)); // R10
  AST_STAGE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !ph_wb) |-> !(rf_wr_en || mem_wr_en)); // R11
  AST_COMMIT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph_wb) |-> !(rf_rd_en || mem_rd_en)); // R11
  AST_COMMIT_HOLDS_STAGE: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && ph_wb) |=> ($stable(stage_s) && $stable(stage_rz))); // R6
  AST_MEM_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd_en && mem_wr_en)); // R8
endmodule

bind operand_stager opstage_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/operand_stager_test.sv
module operand_stager_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start_valid = 1'b0, start_ready, start_wb = 1'b0;
  logic [7:0]  start_opcode = '0;
  logic [3:0]  start_r1 = '0, start_r2 = '0;
  logic [15:0] start_addr = '0;
  logic        done, rf_rd_en, rf_wr_en, mem_rd_en, mem_wr_en;
  logic [3:0]  rf_rd_addr, rf_wr_addr;
  logic [31:0] rf_rd_data, rf_wr_data, mem_wdata, stage_s, stage_rz;
  logic [31:0] mem_rdata = '0;
  logic [15:0] mem_addr, jump_addr;

  logic [31:0] regs [16];
  logic [31:0] mem  [256];
  int n_cmp = 0, n_bad = 0;
  int c_rrd = 0, c_rwr = 0, c_mrd = 0, c_mwr = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  operand_stager uut (.*);

  assign rf_rd_data = regs[rf_rd_addr];

  always @(posedge clk) begin
    if (rf_wr_en)  regs[rf_wr_addr] <= rf_wr_data;
    if (mem_wr_en) mem[mem_addr[7:0]] <= mem_wdata;
    if (mem_rd_en) mem_rdata <= mem[mem_addr[7:0]];
    if (rf_rd_en)  c_rrd <= c_rrd + 1;
    if (rf_wr_en)  c_rwr <= c_rwr + 1;
    if (mem_rd_en) c_mrd <= c_mrd + 1;
    if (mem_wr_en) c_mwr <= c_mwr + 1;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_phase(input bit wb, input logic [7:0] op, input logic [3:0] a,
                           input logic [3:0] b, input logic [15:0] ea);
    int cyc;
    @(negedge clk);
    c_rrd = 0; c_rwr = 0; c_mrd = 0; c_mwr = 0;
    start_valid = 1'b1; start_wb = wb; start_opcode = op;
    start_r1 = a; start_r2 = b; start_addr = ea;
    @(posedge clk);
    @(negedge clk);
    start_valid = 1'b0;
    cyc = 1;
    while (!done && cyc < 10) begin
      @(negedge clk);
      cyc++;
    end
    chk("R10 done latency", cyc, 3);
    @(negedge clk);
    chk("R10 done pulse width", {31'b0, done}, 0);
    chk("R10 ready after phase", {31'b0, start_ready}, 1);
  endtask

  task automatic t_reset;
    chk("R10 reset ready", {31'b0, start_ready}, 1);
    chk("R10 reset done", {31'b0, done}, 0);
    chk("R10 reset stage_s", stage_s, 0);
    chk("R10 reset stage_rz", stage_rz, 0);
    chk("R10 reset jump", {16'b0, jump_addr}, 0);
  endtask

  task automatic t_mem_stage;
    run_phase(0, 8'h01, 4'd3, 4'd9, 16'd10);
    chk("R1 stage_s", stage_s, regs[3]);
    chk("R1 stage_rz", stage_rz, mem[10]);
    chk("R1 mem reads", c_mrd, 1);
    chk("R11 no writes in staging", c_rwr + c_mwr, 0);
    run_phase(0, 8'h14, 4'd5, 4'd0, 16'd20);
    chk("R1 udivmod stage_rz", stage_rz, mem[20]);
  endtask

  task automatic t_regreg_stage;
    run_phase(0, 8'h22, 4'd6, 4'd7, 16'd30);
    chk("R2 stage_s", stage_s, regs[6]);
    chk("R2 stage_rz", stage_rz, regs[7]);
    chk("R2 no mem access", c_mrd + c_mwr, 0);
  endtask

  task automatic t_store_stage;
    logic [31:0] rz0;
    rz0 = stage_rz;
    run_phase(0, 8'h10, 4'd2, 4'd8, 16'd40);
    chk("R3 stage_s", stage_s, regs[2]);
    chk("R3 stage_rz kept", stage_rz, rz0);
    chk("R3 no mem access", c_mrd, 0);
  endtask

  task automatic t_addr_stage;
    run_phase(0, 8'h11, 4'd4, 4'd4, 16'hBEEF);
    chk("R4 stage_s", stage_s, 32'h0000BEEF);
    chk("R4 no reg read", c_rrd, 0);
    chk("R4 no mem access", c_mrd, 0);
  endtask

  task automatic t_jump_halt_stage;
    logic [31:0] s0, z0;
    s0 = stage_s; z0 = stage_rz;
    run_phase(0, 8'h94, 4'd1, 4'd2, 16'h1234);
    chk("R5 jump_addr", {16'b0, jump_addr}, 32'h1234);
    chk("R5 stage_s kept", stage_s, s0);
    chk("R5 stage_rz kept", stage_rz, z0);
    chk("R5 no access", c_rrd + c_mrd + c_rwr + c_mwr, 0);
    run_phase(0, 8'h99, 4'd1, 4'd2, 16'h5555);
    chk("R5 halt jump kept", {16'b0, jump_addr}, 32'h1234);
    chk("R5 halt stage_s kept", stage_s, s0);
    run_phase(0, 8'h07, 4'd1, 4'd2, 16'h6666);
    chk("R5 undefined no access", c_rrd + c_mrd, 0);
    chk("R5 undefined jump kept", {16'b0, jump_addr}, 32'h1234);
  endtask

  task automatic t_dual_commit;
    logic [31:0] s0, z0, mid;
    run_phase(0, 8'h24, 4'hF, 4'd3, 16'd0);
    s0 = stage_s; z0 = stage_rz; mid = regs[1];
    run_phase(1, 8'h24, 4'hF, 4'd3, 16'd0);
    chk("R6 wrap reg A", regs[15], s0);
    chk("R6 wrap reg A+1", regs[0], z0);
    chk("R6 other reg untouched", regs[1], mid);
    chk("R11 no reads in commit", c_rrd + c_mrd, 0);
    run_phase(0, 8'h04, 4'd8, 4'd0, 16'd12);
    s0 = stage_s; z0 = stage_rz;
    run_phase(1, 8'h04, 4'd8, 4'd0, 16'd12);
    chk("R6 reg A", regs[8], s0);
    chk("R6 reg A+1", regs[9], z0);
  endtask

  task automatic t_single_commit;
    run_phase(0, 8'h11, 4'd11, 4'd0, 16'h00AB);
    run_phase(1, 8'h11, 4'd11, 4'd0, 16'h00AB);
    chk("R7 reg A", regs[11], 32'h000000AB);
    chk("R7 one write", c_rwr, 1);
    chk("R7 no mem write", c_mwr, 0);
  endtask

  task automatic t_store_commit;
    run_phase(0, 8'h10, 4'd13, 4'd0, 16'd50);
    run_phase(1, 8'h10, 4'd13, 4'd0, 16'd50);
    chk("R8 mem word", mem[50], regs[13]);
    chk("R8 no reg write", c_rwr, 0);
  endtask

  task automatic t_none_commit;
    logic [7:0] ops [5] = '{8'h05, 8'h25, 8'h83, 8'h99, 8'h07};
    foreach (ops[i]) begin
      run_phase(1, ops[i], 4'd2, 4'd3, 16'd60);
      chk("R9 no writes", c_rwr + c_mwr, 0);
    end
  endtask

  initial begin
    for (int i = 0; i < 16; i++) regs[i] = 32'h1000_0000 + i * 32'h0101;
    for (int i = 0; i < 256; i++) mem[i] = 32'hA000_0000 + i * 7;
    repeat (3) @(posedge clk);
    #1 t_reset;
    @(negedge clk) rst_n = 1'b1;
    t_mem_stage;
    t_regreg_stage;
    t_store_stage;
    t_addr_stage;
    t_jump_halt_stage;
    t_dual_commit;
    t_single_commit;
    t_store_commit;
    t_none_commit;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL R10 watchdog expired actual=hang expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule